// File: doc/BRIEF.md
# Programmed-I/O Request Legality Checker

This block watches a programmed-I/O request port and judges every request that arrives with its valid strobe high. It captures the request on the clock edge, names its class from the read/write bit and the 2-bit command, and runs the rules for that class. Writes are checked on their byte mask. Reads are checked on their size code, on whether the size suits the address space, and on natural alignment of the low address bits.

A failing request raises a one-cycle error flag together with a 3-bit cause. A saturating counter for each cause records how often that cause was seen. A second saturating counter records every accepted request. The captured address, credit, command map and thread are shown next to the flag, so the offending request can be identified.

The parameters choose whether 16-byte reads are supported and whether a non-zero buffer ID counts as an error. The block only observes the port and never stalls or alters the traffic.

Top module: `pio_req_checker`

## Requirements
- R1: One cycle after an edge that samples req_valid_i high, req_vld_o is high for one cycle and req_code_o holds {req_rd_i, req_cmd_i}. The codes are: 000 config write, 001 I/O write, 010 32-bit memory write, 011 64-bit memory write, 100 config read, 101 I/O read, 110 32-bit memory read, 111 64-bit memory read.
- R2: err_o and cause_o appear in the same cycle as req_vld_o. Cause codes are 1 bad size code, 2 size not allowed for the space, 3 misaligned, 4 bad byte mask, 5 non-zero buffer ID. cause_o is 0 and err_o is low for a legal request or when no request is present.
- R3: For config and I/O writes, the byte mask must be one of the following, and anything else gives cause 4 (all-zero included):
  - a single set bit;
  - the pair in bits 1:0, 3:2, 5:4 or 7:6;
  - the nibble in bits 3:0 or 7:4.
- R4: For both memory write codes, every one of the 256 byte-mask values is legal.
- R5: Read size codes are 0=1 B, 1=2 B, 2=4 B, 3=8 B and 4=16 B. Codes 5 to 7 give cause 1. Code 4 also gives cause 1 when WIDE_RD_EN is 0.
- R6: An 8-byte or 16-byte read to config or I/O space gives cause 2.
- R7: A read whose address bits [3:0] are not a multiple of its byte count gives cause 3.
- R8: With WIDE_RD_EN=1, a 16-byte memory read with address bits [3:0]=0 is legal.
- R9: When several rules fail together, the cause reported is the highest in this order: 1, then 2, then 3, then 4, then 5.
- R10: The byte mask has no effect on reads, and the size code has no effect on writes.
- R11: With STRICT_BUF=1, a request with a non-zero buffer ID and no other failure gives cause 5.
- R12: err_cnt_o holds one CW-bit saturating counter per cause. Cause c sits at bits [(c-1)*CW +: CW]. A counter rises by one on the edge after each error of its cause and stops at all ones.
- R13: acc_cnt_o is a CW-bit saturating count of sampled requests, rising on the edge after each req_vld_o. All counters clear on reset.
- R14: req_addr_o, req_credit_o, req_cmap_o and req_thread_o show the fields of the most recently sampled request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| req_valid_i | input | 1 | request strobe |
| req_rd_i | input | 1 | 1 = read, 0 = write |
| req_cmd_i | input | 2 | space: config, I/O, mem32, mem64 |
| req_addr_i | input | AW | physical address |
| req_bmask_i | input | 8 | write byte mask |
| req_size_i | input | 3 | read size code |
| req_credit_i | input | CRW | credit ID |
| req_cmap_i | input | CMW | command map |
| req_buf_i | input | BW | buffer ID |
| req_thread_i | input | TW | CPU thread ID |
| req_vld_o | output | 1 | sampled request present |
| req_code_o | output | 3 | class code of sampled request |
| err_o | output | 1 | rule violation |
| cause_o | output | 3 | cause code |
| req_addr_o | output | AW | captured address |
| req_credit_o | output | CRW | captured credit ID |
| req_cmap_o | output | CMW | captured command map |
| req_thread_o | output | TW | captured thread ID |
| err_cnt_o | output | 5*CW | per-cause saturating counters |
| acc_cnt_o | output | CW | accepted-request counter |

## Verification
The bench sweeps all 256 masks through a config write and a memory write, which separates the 14 legal aligned patterns from the rest. A checker that accepted a shifted pair such as bits 2:1 would be caught here, and so would one that rejected a zero mask on memory. It crosses every read code with every size code and every low-nibble address. This catches a design that lets 8-byte config reads through, mis-sizes the alignment mask, or checks alignment on a 16-byte read without the space rule. Priority cases that fail two or three rules at once expose a wrong ordering. The counters are driven past saturation and would wrap if saturation were broken. A second instance with 16-byte support turned off must flag size code 4.

// File: rtl/pio_chk_pkg.sv
package pio_chk_pkg;

  localparam int NCAUSE = 5;

  typedef enum logic [2:0] {
    C_NONE  = 3'd0,
    C_SIZE  = 3'd1,
    C_SPACE = 3'd2,
    C_ALIGN = 3'd3,
    C_MASK  = 3'd4,
    C_BUF   = 3'd5
  } cause_e;

  typedef enum logic [2:0] {
    SZ_1B  = 3'd0,
    SZ_2B  = 3'd1,
    SZ_4B  = 3'd2,
    SZ_8B  = 3'd3,
    SZ_16B = 3'd4
  } size_e;

  // Naturally aligned 1/2/4-byte masks for config and I/O writes.
  function automatic logic narrow_mask_ok(input logic [7:0] m);
    logic ok;
    ok = 1'b0;
    for (int w = 1; w <= 4; w = w * 2) begin
      for (int s = 0; s < 8; s = s + w) begin
        if (m == 8'(((1 << w) - 1) << s)) ok = 1'b1;
      end
    end
    return ok;
  endfunction

endpackage

// File: rtl/pio_req_reg.sv
module pio_req_reg #(
  parameter int AW  = 36,
  parameter int CRW = 4,
  parameter int CMW = 2,
  parameter int BW  = 1,
  parameter int TW  = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic           rd_i,
  input  logic [1:0]     cmd_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [7:0]     bmask_i,
  input  logic [2:0]     size_i,
  input  logic [CRW-1:0] credit_i,
  input  logic [CMW-1:0] cmap_i,
  input  logic [BW-1:0]  buf_i,
  input  logic [TW-1:0]  thread_i,
  output logic           valid_o,
  output logic           rd_o,
  output logic [1:0]     cmd_o,
  output logic [AW-1:0]  addr_o,
  output logic [7:0]     bmask_o,
  output logic [2:0]     size_o,
  output logic [CRW-1:0] credit_o,
  output logic [CMW-1:0] cmap_o,
  output logic [BW-1:0]  buf_o,
  output logic [TW-1:0]  thread_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  // Fields hold between requests.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_o     <= 1'b0;
      cmd_o    <= '0;
      addr_o   <= '0;
      bmask_o  <= '0;
      size_o   <= '0;
      credit_o <= '0;
      cmap_o   <= '0;
      buf_o    <= '0;
      thread_o <= '0;
    end else if (valid_i) begin
      rd_o     <= rd_i;
      cmd_o    <= cmd_i;
      addr_o   <= addr_i;
      bmask_o  <= bmask_i;
      size_o   <= size_i;
      credit_o <= credit_i;
      cmap_o   <= cmap_i;
      buf_o    <= buf_i;
      thread_o <= thread_i;
    end
  end

  a_hold_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(addr_o) && $stable(thread_o));

endmodule

// File: rtl/pio_rule_eval.sv
module pio_rule_eval
  import pio_chk_pkg::*;
#(
  parameter bit WIDE_RD_EN = 1'b1,
  parameter bit STRICT_BUF = 1'b1,
  parameter int BW         = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          rd_i,
  input  logic [1:0]    cmd_i,
  input  logic [3:0]    addr_lo_i,
  input  logic [7:0]    bmask_i,
  input  logic [2:0]    size_i,
  input  logic [BW-1:0] buf_i,
  output cause_e        cause_o
);

  logic mem_space;
  logic size_bad, space_bad, align_bad, mask_bad, buf_bad;

  assign mem_space = cmd_i[1];

  always_comb begin
    size_bad = 1'b0;
    if (rd_i) begin
      if (size_i > SZ_16B)                     size_bad = 1'b1;
      else if (size_i == SZ_16B && !WIDE_RD_EN) size_bad = 1'b1;
    end
  end

  assign space_bad = rd_i && !mem_space && (size_i == SZ_8B || size_i == SZ_16B);

  always_comb begin
    align_bad = 1'b0;
    if (rd_i) begin
      unique case (size_i)
        SZ_2B:   align_bad = addr_lo_i[0];
        SZ_4B:   align_bad = |addr_lo_i[1:0];
        SZ_8B:   align_bad = |addr_lo_i[2:0];
        SZ_16B:  align_bad = |addr_lo_i[3:0];
        default: align_bad = 1'b0;
      endcase
    end
  end

  assign mask_bad = !rd_i && !mem_space && !narrow_mask_ok(bmask_i);
  assign buf_bad  = STRICT_BUF && (|buf_i);

  always_comb begin
    cause_o = C_NONE;
    if (valid_i) begin
      if      (size_bad)  cause_o = C_SIZE;
      else if (space_bad) cause_o = C_SPACE;
      else if (align_bad) cause_o = C_ALIGN;
      else if (mask_bad)  cause_o = C_MASK;
      else if (buf_bad)   cause_o = C_BUF;
    end
  end

  a_rd_nomask_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && rd_i |-> cause_o != C_MASK);
  a_wr_nosize_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !rd_i |-> !(cause_o inside {C_SIZE, C_SPACE, C_ALIGN}));
  a_mem_wr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !rd_i && mem_space |-> cause_o != C_MASK);
  a_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> cause_o == C_NONE);

endmodule

// File: rtl/pio_sat_cnt.sv
module pio_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_o <= '0;
    else if (inc_i && cnt_o != MAX) cnt_o <= cnt_o + 1'b1;
  end

  a_sat_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o == MAX |=> cnt_o == MAX);
  a_step_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && cnt_o != MAX |=> cnt_o == $past(cnt_o) + 1'b1);
  a_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_o));

endmodule

// File: rtl/pio_req_checker.sv
module pio_req_checker
  import pio_chk_pkg::*;
#(
  parameter int AW         = 36,
  parameter int CRW        = 4,
  parameter int CMW        = 2,
  parameter int BW         = 1,
  parameter int TW         = 6,
  parameter int CW         = 16,
  parameter bit WIDE_RD_EN = 1'b1,
  parameter bit STRICT_BUF = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic               req_rd_i,
  input  logic [1:0]         req_cmd_i,
  input  logic [AW-1:0]      req_addr_i,
  input  logic [7:0]         req_bmask_i,
  input  logic [2:0]         req_size_i,
  input  logic [CRW-1:0]     req_credit_i,
  input  logic [CMW-1:0]     req_cmap_i,
  input  logic [BW-1:0]      req_buf_i,
  input  logic [TW-1:0]      req_thread_i,
  output logic               req_vld_o,
  output logic [2:0]         req_code_o,
  output logic               err_o,
  output logic [2:0]         cause_o,
  output logic [AW-1:0]      req_addr_o,
  output logic [CRW-1:0]     req_credit_o,
  output logic [CMW-1:0]     req_cmap_o,
  output logic [TW-1:0]      req_thread_o,
  output logic [NCAUSE*CW-1:0] err_cnt_o,
  output logic [CW-1:0]      acc_cnt_o
);

  logic         q_rd;
  logic [1:0]   q_cmd;
  logic [7:0]   q_bmask;
  logic [2:0]   q_size;
  logic [BW-1:0] q_buf;
  cause_e       cause;

  pio_req_reg #(.AW(AW), .CRW(CRW), .CMW(CMW), .BW(BW), .TW(TW)) u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (req_valid_i),
    .rd_i     (req_rd_i),
    .cmd_i    (req_cmd_i),
    .addr_i   (req_addr_i),
    .bmask_i  (req_bmask_i),
    .size_i   (req_size_i),
    .credit_i (req_credit_i),
    .cmap_i   (req_cmap_i),
    .buf_i    (req_buf_i),
    .thread_i (req_thread_i),
    .valid_o  (req_vld_o),
    .rd_o     (q_rd),
    .cmd_o    (q_cmd),
    .addr_o   (req_addr_o),
    .bmask_o  (q_bmask),
    .size_o   (q_size),
    .credit_o (req_credit_o),
    .cmap_o   (req_cmap_o),
    .buf_o    (q_buf),
    .thread_o (req_thread_o)
  );

  pio_rule_eval #(.WIDE_RD_EN(WIDE_RD_EN), .STRICT_BUF(STRICT_BUF), .BW(BW)) u_eval (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (req_vld_o),
    .rd_i      (q_rd),
    .cmd_i     (q_cmd),
    .addr_lo_i (req_addr_o[3:0]),
    .bmask_i   (q_bmask),
    .size_i    (q_size),
    .buf_i     (q_buf),
    .cause_o   (cause)
  );

  assign req_code_o = {q_rd, q_cmd};
  assign cause_o    = cause;
  assign err_o      = (cause != C_NONE);

  for (genvar c = 1; c <= NCAUSE; c++) begin : g_cnt
    pio_sat_cnt #(.W(CW)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (err_o && cause_o == 3'(c)),
      .cnt_o  (err_cnt_o[(c-1)*CW +: CW])
    );
  end

  pio_sat_cnt #(.W(CW)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (req_vld_o),
    .cnt_o  (acc_cnt_o)
  );

  a_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> req_vld_o && req_code_o == $past({req_rd_i, req_cmd_i}));
  a_err_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> req_vld_o && cause_o inside {[3'd1:3'd5]});
  a_cfg_wide_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_rd_i && !req_cmd_i[1] && req_size_i == 3'd3
    |=> cause_o == 3'd2);

endmodule

// File: tb/sim_pio_req_checker.sv
`timescale 1ns/1ps
module sim_pio_req_checker;

  localparam int AW = 36, CRW = 4, CMW = 2, BW = 1, TW = 6, CW = 4, NC = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic           v = 1'b0, rd = 1'b0;
  logic [1:0]     cmd = '0;
  logic [AW-1:0]  addr = '0;
  logic [7:0]     bm = '0;
  logic [2:0]     sz = '0;
  logic [CRW-1:0] cr = '0;
  logic [CMW-1:0] cm = '0;
  logic [BW-1:0]  bf = '0;
  logic [TW-1:0]  th = '0;

  logic           vo0, er0, vo1, er1;
  logic [2:0]     code0, cause0, code1, cause1;
  logic [AW-1:0]  ao0, ao1;
  logic [CRW-1:0] cro0, cro1;
  logic [CMW-1:0] cmo0, cmo1;
  logic [TW-1:0]  tho0, tho1;
  logic [NC*CW-1:0] ec0, ec1;
  logic [CW-1:0]  acc0, acc1;

  pio_req_checker #(.CW(CW), .WIDE_RD_EN(1'b1), .STRICT_BUF(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v), .req_rd_i(rd), .req_cmd_i(cmd),
    .req_addr_i(addr), .req_bmask_i(bm), .req_size_i(sz), .req_credit_i(cr),
    .req_cmap_i(cm), .req_buf_i(bf), .req_thread_i(th),
    .req_vld_o(vo0), .req_code_o(code0), .err_o(er0), .cause_o(cause0),
    .req_addr_o(ao0), .req_credit_o(cro0), .req_cmap_o(cmo0), .req_thread_o(tho0),
    .err_cnt_o(ec0), .acc_cnt_o(acc0));

  pio_req_checker #(.CW(CW), .WIDE_RD_EN(1'b0), .STRICT_BUF(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v), .req_rd_i(rd), .req_cmd_i(cmd),
    .req_addr_i(addr), .req_bmask_i(bm), .req_size_i(sz), .req_credit_i(cr),
    .req_cmap_i(cm), .req_buf_i(bf), .req_thread_i(th),
    .req_vld_o(vo1), .req_code_o(code1), .err_o(er1), .cause_o(cause1),
    .req_addr_o(ao1), .req_credit_o(cro1), .req_cmap_o(cmo1), .req_thread_o(tho1),
    .err_cnt_o(ec1), .acc_cnt_o(acc1));

  int checks = 0, errors = 0;
  int exp_cnt [1:NC];
  int exp_acc = 0;
  localparam int MAXC = (1 << CW) - 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Independent model written from the requirements.
  function automatic int model(input logic r, input logic [1:0] c, input logic [3:0] a,
                               input logic [7:0] m, input logic [2:0] s,
                               input logic b, input bit wide, input bit strict);
    int n, lsb;
    if (r) begin
      if (s > 3'd4 || (s == 3'd4 && !wide)) return 1;
      n = 1 << s;
      if (!c[1] && n > 4) return 2;
      if ((int'(a) % n) != 0) return 3;
    end else if (!c[1]) begin
      n = $countones(m);
      lsb = 0;
      for (int i = 7; i >= 0; i--) if (m[i]) lsb = i;
      if (!(n == 1 || n == 2 || n == 4)) return 4;
      if ((lsb % n) != 0) return 4;
      if (m != 8'(((1 << n) - 1) << lsb)) return 4;
    end
    if (strict && b) return 5;
    return 0;
  endfunction

  // Drive at a falling edge, check after the capturing edge.
  task automatic send(input string req, input logic r, input logic [1:0] c,
                      input logic [AW-1:0] a, input logic [7:0] m, input logic [2:0] s,
                      input logic b);
    int e0, e1;
    v = 1'b1; rd = r; cmd = c; addr = a; bm = m; sz = s; bf = b;
    @(negedge clk);
    v = 1'b0;
    e0 = model(r, c, a[3:0], m, s, b, 1'b1, 1'b1);
    e1 = model(r, c, a[3:0], m, s, b, 1'b0, 1'b0);
    chk({req, " vld"}, 64'(vo0), 64'd1);
    chk({req, " code"}, 64'(code0), 64'({r, c}));
    chk({req, " cause"}, 64'(cause0), 64'(e0));
    chk({req, " err"}, 64'(er0), 64'(e0 != 0));
    chk({req, " cause u1"}, 64'(cause1), 64'(e1));
    if (e0 != 0 && exp_cnt[e0] < MAXC) exp_cnt[e0]++;
    if (exp_acc < MAXC) exp_acc++;
  endtask

  task automatic idle_check_cnt(input string req);
    @(negedge clk);
    chk({req, " err idle R2"}, 64'(er0), 64'd0);
    for (int c = 1; c <= NC; c++)
      chk({req, " cnt R12"}, 64'(ec0[(c-1)*CW +: CW]), 64'(exp_cnt[c]));
    chk({req, " acc R13"}, 64'(acc0), 64'(exp_acc));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 1; c <= NC; c++) exp_cnt[c] = 0;
    exp_acc = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("reset vld R1", 64'(vo0), 64'd0);
    chk("reset err R2", 64'(er0), 64'd0);
    chk("reset cnt R12", 64'(ec0), 64'd0);
    chk("reset acc R13", 64'(acc0), 64'd0);
  endtask

  task automatic t_classify();
    for (int k = 0; k < 8; k++)
      send("R1 class", k[2], k[1:0], 36'h0, 8'h01, 3'd0, 1'b0);
    idle_check_cnt("R1");
  endtask

  task automatic t_masks();
    for (int m = 0; m < 256; m++) begin
      send("R3 cfg wr mask", 1'b0, 2'd0, 36'h8, 8'(m), 3'd0, 1'b0);
      send("R4 mem wr mask", 1'b0, 2'd3, 36'h0, 8'(m), 3'd0, 1'b0);
    end
    send("R3 io pair bad", 1'b0, 2'd1, 36'h0, 8'h06, 3'd0, 1'b0);
    chk("R3 pair 2:1 cause", 64'(cause0), 64'd4);
    send("R3 io nibble ok", 1'b0, 2'd1, 36'h0, 8'hF0, 3'd0, 1'b0);
    chk("R3 nibble 7:4 cause", 64'(cause0), 64'd0);
    do_reset();
  endtask

  task automatic t_reads();
    for (int k = 4; k < 8; k++)
      for (int s = 0; s < 8; s++)
        for (int a = 0; a < 16; a++)
          send("R5 R6 R7 R8 read", 1'b1, k[1:0], 36'(a), 8'h00, 3'(s), 1'b0);
    send("R8 mem 16B aligned", 1'b1, 2'd2, 36'h0, 8'h00, 3'd4, 1'b0);
    chk("R8 16B legal", 64'(cause0), 64'd0);
    chk("R5 16B off u1", 64'(cause1), 64'd1);
    do_reset();
  endtask

  task automatic t_priority();
    send("R9 cfg 8B misaligned", 1'b1, 2'd0, 36'h3, 8'h00, 3'd3, 1'b1);
    chk("R9 space over align", 64'(cause0), 64'd2);
    send("R9 io bad code misaligned", 1'b1, 2'd1, 36'h1, 8'h00, 3'd6, 1'b1);
    chk("R9 size first", 64'(cause0), 64'd1);
    send("R9 mem 4B misaligned buf", 1'b1, 2'd3, 36'h2, 8'h00, 3'd2, 1'b1);
    chk("R9 align over buf", 64'(cause0), 64'd3);
    send("R9 cfg wr mask buf", 1'b0, 2'd0, 36'h0, 8'h05, 3'd0, 1'b1);
    chk("R9 mask over buf", 64'(cause0), 64'd4);
    idle_check_cnt("R9");
  endtask

  task automatic t_ignored();
    send("R10 rd mask ignored", 1'b1, 2'd0, 36'h0, 8'h55, 3'd0, 1'b0);
    chk("R10 rd mask", 64'(er0), 64'd0);
    send("R10 wr size ignored", 1'b0, 2'd1, 36'h3, 8'h08, 3'd7, 1'b0);
    chk("R10 wr size", 64'(er0), 64'd0);
  endtask

  task automatic t_buf();
    send("R11 buf strict", 1'b0, 2'd2, 36'h0, 8'hFF, 3'd0, 1'b1);
    chk("R11 cause 5", 64'(cause0), 64'd5);
    chk("R11 non-strict u1", 64'(er1), 64'd0);
    idle_check_cnt("R11");
  endtask

  task automatic t_echo();
    cr = 4'hA; cm = 2'd3; th = 6'd45;
    send("R14 echo", 1'b1, 2'd3, 36'hF_1234_5678, 8'h00, 3'd3, 1'b0);
    chk("R14 addr", 64'(ao0), 64'h0_F_1234_5678);
    chk("R14 credit", 64'(cro0), 64'hA);
    chk("R14 cmap", 64'(cmo0), 64'd3);
    chk("R14 thread", 64'(tho0), 64'd45);
    cr = '0; cm = '0; th = '0;
  endtask

  task automatic t_saturate();
    for (int i = 0; i < MAXC + 3; i++)
      send("R12 sat", 1'b0, 2'd0, 36'h0, 8'h00, 3'd0, 1'b0);
    idle_check_cnt("R12 R13 saturate");
    chk("R12 mask cnt full", 64'(ec0[3*CW +: CW]), 64'(MAXC));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 1; c <= NC; c++) exp_cnt[c] = 0;
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_classify();
    t_masks();
    t_reads();
    t_priority();
    t_ignored();
    t_buf();
    t_echo();
    t_saturate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule